// File: doc/BRIEF.md
# Local Interrupt Vector Table

This block sits between six local interrupt sources of a processor core and the interrupt acceptor that feeds the core. The sources are the timer, the thermal monitor, the performance counter, two external local pins and the error reporter. Each source owns one 32-bit configuration entry. An entry holds the vector number, a delivery mode, the active polarity of the pin, the choice between edge and level sensing, and a mask.

The block samples every source each clock and applies the entry's polarity. It then detects an edge or a level and latches a pending request. Pending requests go one at a time to the acceptor, with the vector and the delivery mode, and the lowest-numbered entry wins. A level-sensed source that has been accepted sets a remote-request flag. That flag blocks further requests from the source until an end-of-interrupt names the source's vector.

Software reaches the entries through a plain address/data bus. A read-only version word reports the highest entry index built. That index also decides whether the performance-counter and thermal entries exist at all.

Top module: `lvt_ctrl`

## Requirements
- R1: Entry n sits at byte offset 0x10*n, with n = 0 timer, 1 thermal, 2 performance counter, 3 local pin 0, 4 local pin 1, 5 error. The version word at offset 0x80 reads the highest entry index in bits 23:16 and an identifier (default 0x14) in bits 7:0. Any other offset reads zero.
- R2: Entry bit fields are: vector 7:0, delivery mode 10:8, delivery status 12 (1 = pending), polarity 13 (1 = active-low), remote-request flag 14, trigger 15 (1 = level, 0 = edge), mask 16 (1 = masked). The writable fields read back as written, and every other bit reads zero.
- R3: Writes to the delivery-status bit and the remote-request bit are ignored.
- R4: After reset, the timer and error entries read 0x00010000 (masked) and every other entry reads zero.
- R5: The performance-counter entry exists only when the highest index is at least 4, and the thermal entry only when it is at least 5. An absent entry reads zero, ignores writes and never requests.
- R6: An unmasked edge entry sets delivery status on the clock edge that sees its polarity-adjusted input go from inactive to active. A held active input does not retrigger it.
- R7: An unmasked level entry requests while its adjusted input is active and its remote flag is clear. Acceptance of its request sets the remote flag. It cannot request again until an end-of-interrupt carrying its vector clears that flag.
- R8: A masked entry never sets delivery status.
- R9: Delivery status stays set until the acceptor acknowledges. req_valid shows whether any entry is pending and presents the lowest-numbered pending entry. req_ack clears exactly that entry.
- R10: The delivery mode (000 fixed, 010 SMI, 100 NMI, 111 external) and the vector of the presented entry appear unchanged on req_mode and req_vector.
- R11: An end-of-interrupt whose vector differs from the entry's vector leaves the remote flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_in | input | 6 | Raw local source inputs, bit n for entry n |
| req_valid | output | 1 | A request is presented to the acceptor |
| req_vector | output | 8 | Vector of the presented request |
| req_mode | output | 3 | Delivery mode of the presented request |
| req_ack | input | 1 | Acceptor takes the presented request |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector named by the end-of-interrupt |

## Verification
The assertions assume that the source inputs are synchronous to clk and held steady across each edge. They also assume that req_ack is raised only as a single-cycle pulse. The bench drives sources, strobes and bus writes at the falling edge and pulses acknowledge and end-of-interrupt for one cycle each. It programs an entry's polarity and trigger while the entry is masked, so a polarity change is never taken for an edge. Randomised register traffic keeps the mask bit set, so that only the directed phases raise requests.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

  localparam int NUM_SRC    = 6;
  localparam int IRQ_TIMER  = 0;
  localparam int IRQ_THERM  = 1;
  localparam int IRQ_PERF   = 2;
  localparam int IRQ_PIN0   = 3;
  localparam int IRQ_PIN1   = 4;
  localparam int IRQ_ERR    = 5;
  localparam int STRIDE     = 16;
  localparam int VER_OFFSET = 128;

  localparam int B_MODE_LO = 8;
  localparam int B_MODE_HI = 10;
  localparam int B_STATUS  = 12;
  localparam int B_POL     = 13;
  localparam int B_REMOTE  = 14;
  localparam int B_TRIG    = 15;
  localparam int B_MASK    = 16;

  typedef struct packed {
    logic       mask;
    logic       level;
    logic       act_low;
    logic [2:0] mode;
    logic [7:0] vector;
  } lvt_cfg_t;

  function automatic lvt_cfg_t cfg_from_word(input logic [31:0] w);
    lvt_cfg_t c;
    c.mask    = w[B_MASK];
    c.level   = w[B_TRIG];
    c.act_low = w[B_POL];
    c.mode    = w[B_MODE_HI:B_MODE_LO];
    c.vector  = w[7:0];
    return c;
  endfunction

  function automatic logic [31:0] word_of(input lvt_cfg_t c, input logic pend,
                                          input logic rem);
    logic [31:0] w;
    w = '0;
    w[7:0]                 = c.vector;
    w[B_MODE_HI:B_MODE_LO] = c.mode;
    w[B_STATUS]            = pend;
    w[B_POL]               = c.act_low;
    w[B_REMOTE]            = rem;
    w[B_TRIG]              = c.level;
    w[B_MASK]              = c.mask;
    return w;
  endfunction

  function automatic logic pol_adjust(input logic raw, input logic act_low);
    return raw ^ act_low;
  endfunction

  function automatic bit entry_present(input int irq, input int max_idx);
    if (irq == IRQ_PERF)  return max_idx >= 4;
    if (irq == IRQ_THERM) return max_idx >= 5;
    return 1'b1;
  endfunction

  function automatic logic [31:0] version_word(input int max_idx, input logic [7:0] id);
    logic [31:0] w;
    w = '0;
    w[23:16] = 8'(max_idx);
    w[7:0]   = id;
    return w;
  endfunction

endpackage

// File: rtl/lvt_entry.sv
module lvt_entry
  import lvt_pkg::*;
#(
  parameter int IRQ        = 0,
  parameter int MAX_LVT    = 5,
  parameter bit RST_MASKED = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        src_raw,
  input  logic        accept,
  input  logic        eoi_valid,
  input  logic [7:0]  eoi_vector,
  output logic        pending,
  output logic [7:0]  vector,
  output logic [2:0]  mode,
  output logic [31:0] rd_word
);

  localparam bit PRESENT = entry_present(IRQ, MAX_LVT);

  generate
    if (PRESENT) begin : g_live
      lvt_cfg_t cfg_q;
      logic     pend_q;
      logic     rem_q;
      logic     act_q;
      logic     active;
      logic     edge_evt;
      logic     trig_fire;
      logic     eoi_hit;

      assign active    = pol_adjust(src_raw, cfg_q.act_low);
      assign edge_evt  = active & ~act_q;
      assign trig_fire = ~cfg_q.mask & ~pend_q &
                         (cfg_q.level ? (active & ~rem_q) : edge_evt);
      assign eoi_hit   = eoi_valid && (eoi_vector == cfg_q.vector);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cfg_q      <= '0;
          cfg_q.mask <= RST_MASKED;
          pend_q     <= 1'b0;
          rem_q      <= 1'b0;
          act_q      <= 1'b0;
        end else begin
          act_q <= active;
          if (wr_en) cfg_q <= cfg_from_word(wdata);
          if (trig_fire)   pend_q <= 1'b1;
          else if (accept) pend_q <= 1'b0;
          if (accept && cfg_q.level) rem_q <= 1'b1;
          else if (eoi_hit)          rem_q <= 1'b0;
        end
      end

      assign pending = pend_q;
      assign vector  = cfg_q.vector;
      assign mode    = cfg_q.mode;
      assign rd_word = word_of(cfg_q, pend_q, rem_q);

      // R8
      masked_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> !$past(cfg_q.mask));
      // R9
      status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !accept) |=> pend_q);
      // R7
      remote_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_q && cfg_q.level && !eoi_hit) |=> !$rose(pend_q));
      // R7
      remote_by_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rem_q) |-> $past(accept));
      // R6
      edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pend_q) && !$past(cfg_q.level)) |-> !$past(act_q));
    end else begin : g_absent
      logic unused_in;
      assign unused_in = ^{clk, rst_n, wr_en, wdata, src_raw, accept, eoi_valid, eoi_vector};
      assign pending   = 1'b0;
      assign vector    = '0;
      assign mode      = '0;
      assign rd_word   = '0;
    end
  endgenerate

endmodule

// File: rtl/lvt_arbiter.sv
module lvt_arbiter #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  output logic [N-1:0] grant,
  output logic         any
);

  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign any = |grant;

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R9
  grant_to_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pend) == '0);
  // R9
  grant_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> any);

endmodule

// File: rtl/lvt_regif.sv
module lvt_regif
  import lvt_pkg::*;
#(
  parameter int         N       = 6,
  parameter int         ADDR_W  = 8,
  parameter int         MAX_LVT = 5,
  parameter logic [7:0] VER_ID  = 8'h14
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       words [N],
  output logic [N-1:0]      wr_sel,
  output logic [31:0]       bus_rdata
);

  localparam logic [ADDR_W-1:0] VER_A = ADDR_W'(VER_OFFSET);

  always_comb begin
    wr_sel    = '0;
    bus_rdata = '0;
    if (bus_addr == VER_A) bus_rdata = version_word(MAX_LVT, VER_ID);
    for (int i = 0; i < N; i++) begin
      if (bus_addr == ADDR_W'(i * STRIDE)) begin
        wr_sel[i] = bus_wr;
        bus_rdata = words[i];
      end
    end
  end

endmodule

// File: rtl/lvt_ctrl.sv
module lvt_ctrl
  import lvt_pkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter int         MAX_LVT = 5,
  parameter logic [7:0] VER_ID  = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic              req_valid,
  output logic [7:0]        req_vector,
  output logic [2:0]        req_mode,
  input  logic              req_ack,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector
);

  logic [NUM_SRC-1:0] wr_sel;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] accept;
  logic [7:0]         vec_of  [NUM_SRC];
  logic [2:0]         mode_of [NUM_SRC];
  logic [31:0]        words   [NUM_SRC];
  logic               any_pend;

  lvt_regif #(.N(NUM_SRC), .ADDR_W(ADDR_W), .MAX_LVT(MAX_LVT), .VER_ID(VER_ID)) regif_i (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .words    (words),
    .wr_sel   (wr_sel),
    .bus_rdata(bus_rdata)
  );

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
      localparam bit RMASK = (g == IRQ_TIMER) || (g == IRQ_ERR);
      assign accept[g] = req_ack & grant[g];
      lvt_entry #(.IRQ(g), .MAX_LVT(MAX_LVT), .RST_MASKED(RMASK)) ent_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_sel[g]),
        .wdata     (bus_wdata),
        .src_raw   (src_in[g]),
        .accept    (accept[g]),
        .eoi_valid (eoi_valid),
        .eoi_vector(eoi_vector),
        .pending   (pend[g]),
        .vector    (vec_of[g]),
        .mode      (mode_of[g]),
        .rd_word   (words[g])
      );
    end
  endgenerate

  lvt_arbiter #(.N(NUM_SRC)) arb_i (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (pend),
    .grant(grant),
    .any  (any_pend)
  );

  always_comb begin
    req_vector = '0;
    req_mode   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) begin
        req_vector = vec_of[i];
        req_mode   = mode_of[i];
      end
    end
  end

  assign req_valid = any_pend;

  // R9
  req_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> req_valid);
  // R4
  idle_after_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !req_valid);

endmodule

// File: tb/lvt_ctrl_tb_top.sv
module lvt_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_wr2;
  logic [31:0] bus_wdata, rdata, rdata2;
  logic [5:0]  src, src2;
  logic        req_ack, eoi_valid;
  logic [7:0]  eoi_vector;
  logic        req_valid, req_valid2;
  logic [7:0]  req_vector, req_vector2;
  logic [2:0]  req_mode, req_mode2;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;

  always #10 clk = ~clk;

  lvt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .src_in(src),
    .req_valid(req_valid), .req_vector(req_vector), .req_mode(req_mode),
    .req_ack(req_ack), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
  );

  lvt_ctrl #(.MAX_LVT(3)) dut_small (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr2),
    .bus_wdata(bus_wdata), .bus_rdata(rdata2), .src_in(src2),
    .req_valid(req_valid2), .req_vector(req_vector2), .req_mode(req_mode2),
    .req_ack(1'b0), .eoi_valid(1'b0), .eoi_vector(8'h00)
  );

  function automatic logic [31:0] exp_rb(input logic [31:0] d);
    return d & 32'h0001_A7FF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic wr2(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr2 = 1'b1;
    step();
    bus_wr2 = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d2);
    bus_addr = a;
    #1;
    d = rdata; d2 = rdata2;
  endtask

  task automatic ack();
    req_ack = 1'b1;
    step();
    req_ack = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_vector = v; eoi_valid = 1'b1;
    step();
    eoi_valid = 1'b0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic [2:0]  modes [4];
    modes[0] = 3'b000; modes[1] = 3'b010; modes[2] = 3'b100; modes[3] = 3'b111;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wr2 = 1'b0; bus_wdata = '0;
    src = '0; src2 = '0; req_ack = 1'b0; eoi_valid = 1'b0; eoi_vector = '0;
    step(3);
    rst_n = 1'b1;
    step();

    // R4: reset values, R1: map and version
    for (int i = 0; i < 6; i++) begin
      rd(8'(i * 16), d, d2);
      check("R4 reset entry", d, (i == 0 || i == 5) ? 32'h0001_0000 : 32'h0);
    end
    check("R4 no request after reset", {31'b0, req_valid}, 32'h0);
    rd(8'h80, d, d2);
    check("R1 version word", d, 32'h0005_0014);
    rd(8'h08, d, d2);
    check("R1 unmapped offset 0x08", d, 32'h0);
    rd(8'h60, d, d2);
    check("R1 unmapped offset 0x60", d, 32'h0);

    // R2, R3: all-ones write readback
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, d, d2);
    check("R2 R3 all-ones readback", d, 32'h0001_A7FF);

    // R2, R3, R8: random masked register traffic
    for (int k = 0; k < 40; k++) begin
      int idx;
      logic [31:0] v;
      idx = int'($urandom % 6);
      v = $urandom | 32'h0001_0000;
      wr(8'(idx * 16), v);
      rd(8'(idx * 16), d, d2);
      check("R2 random readback", d, exp_rb(v));
      check("R8 masked random no request", {31'b0, req_valid}, 32'h0);
    end
    for (int i = 0; i < 6; i++) wr(8'(i * 16), 32'h0001_0000);
    step();

    // R6: edge detection on pin 0, vector 0x41, external mode
    wr(8'h30, 32'h0000_0741);
    src[3] = 1'b1;
    step();
    check("R6 edge raises request", {31'b0, req_valid}, 32'h1);
    check("R10 external vector", {24'b0, req_vector}, 32'h41);
    check("R10 external mode", {29'b0, req_mode}, 32'h7);
    rd(8'h30, d, d2);
    check("R2 status bit while pending", d, 32'h0000_1741);
    ack();
    check("R9 ack clears request", {31'b0, req_valid}, 32'h0);
    step(3);
    check("R6 held input no retrigger", {31'b0, req_valid}, 32'h0);
    src[3] = 1'b0;
    step(2);
    src[3] = 1'b1;
    step();
    check("R6 second edge", {31'b0, req_valid}, 32'h1);
    ack();
    src[3] = 1'b0;

    // R9: pending held without ack
    wr(8'h40, 32'h0000_0452);
    src[4] = 1'b1;
    step(6);
    check("R9 held pending", {31'b0, req_valid}, 32'h1);
    rd(8'h40, d, d2);
    check("R9 status bit held", d, 32'h0000_1452);
    wr(8'h40, 32'h0000_1452 | 32'h0000_4000);
    rd(8'h40, d, d2);
    check("R3 status and remote writes ignored", d, 32'h0000_1452);
    ack();
    src[4] = 1'b0;
    step();

    // R9, R10: priority of lowest index
    wr(8'h00, 32'h0000_0030);
    src[0] = 1'b1; src[4] = 1'b1;
    step();
    check("R9 priority vector first", {24'b0, req_vector}, 32'h30);
    check("R10 fixed mode", {29'b0, req_mode}, 32'h0);
    ack();
    check("R9 second still valid", {31'b0, req_valid}, 32'h1);
    check("R9 priority vector second", {24'b0, req_vector}, 32'h52);
    check("R10 NMI mode", {29'b0, req_mode}, 32'h4);
    ack();
    check("R9 all served", {31'b0, req_valid}, 32'h0);
    src[0] = 1'b0; src[4] = 1'b0;
    step();

    // R7, R11: level, active-low error entry
    src[5] = 1'b1;
    wr(8'h50, 32'h0000_A066);
    step();
    check("R7 inactive level no request", {31'b0, req_valid}, 32'h0);
    src[5] = 1'b0;
    step();
    check("R7 level request", {31'b0, req_valid}, 32'h1);
    check("R7 level vector", {24'b0, req_vector}, 32'h66);
    ack();
    rd(8'h50, d, d2);
    check("R7 remote set after accept", d, 32'h0000_E066);
    step(3);
    check("R7 remote blocks request", {31'b0, req_valid}, 32'h0);
    eoi(8'h67);
    step();
    rd(8'h50, d, d2);
    check("R11 other vector keeps remote", d, 32'h0000_E066);
    check("R11 still blocked", {31'b0, req_valid}, 32'h0);
    eoi(8'h66);
    step();
    check("R7 request after matching eoi", {31'b0, req_valid}, 32'h1);
    src[5] = 1'b1;
    ack();
    eoi(8'h66);
    step();
    rd(8'h50, d, d2);
    check("R7 clean after second eoi", d, 32'h0000_A066);
    check("R7 idle when inactive", {31'b0, req_valid}, 32'h0);

    // R8: masked edge
    wr(8'h00, 32'h0001_0031);
    src[0] = 1'b1;
    step(2);
    check("R8 masked edge no request", {31'b0, req_valid}, 32'h0);
    rd(8'h00, d, d2);
    check("R8 masked status clear", d, 32'h0001_0031);
    wr(8'h00, 32'h0000_0031);
    step(2);
    check("R6 unmask while high no edge", {31'b0, req_valid}, 32'h0);
    src[0] = 1'b0;
    wr(8'h00, 32'h0001_0000);

    // R10: random edge requests
    for (int k = 0; k < 24; k++) begin
      int idx;
      logic [7:0] vec;
      logic [2:0] md;
      idx = int'($urandom % 5);
      vec = 8'($urandom);
      md  = modes[$urandom % 4];
      wr(8'(idx * 16), {21'b0, md, vec});
      src[idx] = 1'b1;
      step();
      check("R6 random edge valid", {31'b0, req_valid}, 32'h1);
      check("R10 random vector", {24'b0, req_vector}, {24'b0, vec});
      check("R10 random mode", {29'b0, req_mode}, {29'b0, md});
      src[idx] = 1'b0;
      ack();
      check("R9 random ack clears", {31'b0, req_valid}, 32'h0);
      wr(8'(idx * 16), 32'h0001_0000);
    end

    // R5: small build without perf counter and thermal entries
    rd(8'h80, d, d2);
    check("R5 small version", d2, 32'h0003_0014);
    wr2(8'h10, 32'h0000_0041);
    wr2(8'h20, 32'h0000_0041);
    rd(8'h10, d, d2);
    check("R5 thermal absent reads zero", d2, 32'h0);
    rd(8'h20, d, d2);
    check("R5 perf absent reads zero", d2, 32'h0);
    src2[1] = 1'b1; src2[2] = 1'b1;
    step(2);
    check("R5 absent never requests", {31'b0, req_valid2}, 32'h0);
    src2[3] = 1'b1;
    step();
    check("R5 present pin requests", {31'b0, req_valid2}, 32'h1);

    done = 1'b1;
    report();
    $finish;
  end

endmodule